// File: doc/BRIEF.md
# Reset Sequencer and Host Register Guard

This block sits between a host register bus and a small set of device control registers. It watches an active-low hardware reset pin and decides whether a low pulse is a real reset. The minimum pulse width is long while the device is still powering up and short once it is running. After any accepted reset it holds the host off for a fixed settling time. Host accesses made while the block is not ready are discarded: reads return zero and writes are dropped.

The bank holds three registers. A line-mode register selects E1 versus T1/J1 framing. A power-down register carries a receive-off bit and a transmit-off bit for each link. A write-only software-reset register returns every register except line mode to its default. The line mode is cleared only by a hardware reset. Writing it raises a pending flag, which tells the host that a software reset is still owed. The power-down bits gate each link's data path. A powered-down receive path drives low. A powered-down transmit path drops its output enable, which models high impedance.

All durations are parameters in nanoseconds or microseconds, converted to clock cycles from a clock-frequency parameter. The power-up phase starts at the system reset and ends when the first accepted hardware reset is released.

Top module: `rsg_top`

## Requirements
- R1: After the synchronous system reset, `host_ready` is 0, `in_powerup` is 1, all power-down bits are 0 (so the receive outputs follow their inputs and every transmit enable is 1), and the line mode is 0.
- R2: While `in_powerup` is 1, a low pulse on `rst_pin_n` shorter than the power-up threshold is ignored. A pulse of at least that many cycles is accepted, and `in_powerup` falls to 0 when the pin returns high. It never rises again until the next system reset.
- R3: Once the power-up phase is over, a low pulse of at least the run threshold is accepted as a hardware reset. A shorter pulse is ignored: `host_ready` and all register contents are unchanged.
- R4: The pin passes through a two-stage synchronizer. `host_ready` is 0 while an accepted reset is held, and it rises exactly SETTLE+3 clock edges after the first edge that samples the pin high again, where SETTLE is the settling time in cycles.
- R5: When `host_ready` is 0, a read returns 0 on `host_rdata` one cycle later, and a write changes no register.
- R6: A write to address 0x2 while ready clears the power-down register and the pending flag. `host_ready` is then 0 from the next cycle until it rises SETTLE+1 edges after the write edge.
- R7: The line-mode register is at address 0x0, bit 0 (1 = E1). It is kept across a software reset and cleared by every accepted hardware reset.
- R8: An accepted write to address 0x0 sets the pending flag, which reads back as bit 7 of address 0x0. A software reset clears it.
- R9: The power-down register is at address 0x1. Bit i (i < 4) set forces `rx_line_o[i]` to 0. When it is clear, `rx_line_o[i]` follows `rx_line_i[i]`.
- R10: In the power-down register, bit 4+i set drives `tx_line_oe[i]` to 0. `tx_line_o` always follows `tx_line_i`.
- R11: A software-reset write can arrive in the same cycle as the edge at which a hardware pulse is accepted. In that case the hardware reset takes precedence: the line mode is cleared as well.
- R12: Host reads are registered. `host_rdata` shows the addressed register one cycle after `host_rd`, and 0 in every other cycle. Unmapped addresses and address 0x2 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset; starts the power-up phase |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data, 0 when not reading or not ready |
| host_ready | output | 1 | High when the host may access the registers |
| in_powerup | output | 1 | High until the first accepted hardware reset completes |
| line_mode_e1 | output | 1 | Current line mode (1 = E1, 0 = T1/J1) |
| rx_line_i | input | NUM_LINKS | Receive data from each link |
| rx_line_o | output | NUM_LINKS | Gated receive data |
| tx_line_i | input | NUM_LINKS | Transmit data to each link |
| tx_line_o | output | NUM_LINKS | Transmit data |
| tx_line_oe | output | NUM_LINKS | Transmit output enable per link |

## Verification
A software-reset write and the acceptance of a hardware pulse can fall on the same clock edge, and the two disagree about the line-mode register. The bench drops the pin low and counts through the synchronizer and the width counter. It then presents the software-reset write in exactly the cycle whose closing edge accepts the pulse. It judges the result in two ways. `host_ready` must reappear on the timing measured from the pin release. The line-mode register, set to E1 beforehand, must read back as zero. If the software reset had won, the register would still read E1.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_WAIT_POR = 2'd0,  // power-up, waiting for the first accepted pin reset
        ST_HOLD     = 2'd1,  // accepted reset, pin still low
        ST_SETTLE   = 2'd2,  // settling window, host blocked
        ST_OPEN     = 2'd3   // host access allowed
    } seq_state_e;

    // Decoded register selection
    typedef enum logic [1:0] {
        RS_MODE  = 2'd0,
        RS_PWRDN = 2'd1,
        RS_SWRST = 2'd2,
        RS_NONE  = 2'd3
    } reg_sel_e;

    // Events produced by the pin qualifier
    typedef struct packed {
        logic low;  // synchronized pin level is low
        logic hit;  // this cycle's low sample completes a qualified pulse
    } pin_ev_t;

    // Decoded host access
    typedef struct packed {
        logic     wr_ok;
        logic     rd_ok;
        reg_sel_e sel;
    } host_acc_t;

    // Duration in nanoseconds to clock cycles, rounded up, minimum one
    function automatic longint unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + NS_PER_SEC - 64'd1) / NS_PER_SEC;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic reg_sel_e decode_addr(int unsigned a);
        case (a)
            0:       return RS_MODE;
            1:       return RS_PWRDN;
            2:       return RS_SWRST;
            default: return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rsg_pin_qual.sv
module rsg_pin_qual
    import rsg_pkg::*;
#(
    parameter int unsigned RUN_CYC = 2,
    parameter int unsigned PWR_CYC = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_n,
    input  logic    pwrup,
    output pin_ev_t ev
);
    localparam int unsigned MAX_CYC = (PWR_CYC > RUN_CYC) ? PWR_CYC : RUN_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;
    logic [CW-1:0]          thr;
    logic                   low;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign low = ~sync_q[SYNC_STAGES-1];

    // Width counter saturates so a long pulse qualifies exactly once
    always_ff @(posedge clk) begin
        if (rst || !low)         low_cnt_q <= '0;
        else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + CW'(1);
    end

    assign thr    = pwrup ? CW'(PWR_CYC - 1) : CW'(RUN_CYC - 1);
    assign ev.low = low;
    assign ev.hit = low && (low_cnt_q == thr);

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ev.hit |=> !ev.hit);

endmodule

// File: rtl/rsg_sequencer.sv
module rsg_sequencer
    import rsg_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  pin_ev_t ev,
    input  logic    sw_rst_req,
    output logic    ready,
    output logic    pwrup
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

    seq_state_e    st_q, st_d;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          pwrup_q, pwrup_d;

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        pwrup_d = pwrup_q;
        if (ev.hit) begin
            st_d = ST_HOLD;   // hardware reset outranks everything
        end else begin
            unique case (st_q)
                ST_WAIT_POR: ;
                ST_HOLD: begin
                    if (!ev.low) begin
                        st_d    = ST_SETTLE;
                        cnt_d   = SW'(SETTLE_CYC - 1);
                        pwrup_d = 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) st_d = ST_OPEN;
                    else             cnt_d = cnt_q - SW'(1);
                end
                ST_OPEN: begin
                    if (sw_rst_req) begin
                        st_d  = ST_SETTLE;
                        cnt_d = SW'(SETTLE_CYC - 1);
                    end
                end
                default: st_d = ST_WAIT_POR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_WAIT_POR;
            cnt_q   <= '0;
            pwrup_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            pwrup_q <= pwrup_d;
        end
    end

    assign ready = (st_q == ST_OPEN);
    assign pwrup = pwrup_q;

    // R4
    open_from_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(st_q) == ST_SETTLE));

    // R4
    settle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE && cnt_q != '0 && !ev.hit) |=> (st_q == ST_SETTLE));

    // R2
    pwrup_no_return_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(pwrup_q));

    // R11
    hit_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ev.hit |=> (st_q == ST_HOLD));

endmodule

// File: rtl/rsg_regbank.sv
module rsg_regbank
    import rsg_pkg::*;
#(
    parameter int unsigned NUM_LINKS = 4,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hw_hit,
    input  logic                 ready,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 sw_rst_req,
    output logic                 mode_e1,
    output logic [NUM_LINKS-1:0] rx_off,
    output logic [NUM_LINKS-1:0] tx_off
);
    localparam int unsigned PD_W = 2 * NUM_LINKS;

    host_acc_t          acc;
    logic               mode_q, pend_q;
    logic [NUM_LINKS-1:0] rx_off_q, tx_off_q;
    logic [DATA_W-1:0]  rd_mux;

    always_comb begin
        acc.sel   = decode_addr(int'(addr));
        acc.wr_ok = wr_en && ready;
        acc.rd_ok = rd_en && ready;
    end

    assign sw_rst_req = acc.wr_ok && (acc.sel == RS_SWRST);

    // Hardware reset clears all; software reset spares the line mode
    always_ff @(posedge clk) begin
        if (rst || hw_hit) begin
            mode_q   <= 1'b0;
            pend_q   <= 1'b0;
            rx_off_q <= '0;
            tx_off_q <= '0;
        end else if (sw_rst_req) begin
            pend_q   <= 1'b0;
            rx_off_q <= '0;
            tx_off_q <= '0;
        end else if (acc.wr_ok) begin
            if (acc.sel == RS_MODE) begin
                mode_q <= wdata[0];
                pend_q <= 1'b1;
            end
            if (acc.sel == RS_PWRDN) begin
                rx_off_q <= wdata[NUM_LINKS-1:0];
                tx_off_q <= wdata[PD_W-1:NUM_LINKS];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (acc.sel)
            RS_MODE: begin
                rd_mux[0]        = mode_q;
                rd_mux[DATA_W-1] = pend_q;
            end
            RS_PWRDN: begin
                rd_mux[NUM_LINKS-1:0] = rx_off_q;
                rd_mux[PD_W-1:NUM_LINKS] = tx_off_q;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (acc.rd_ok) rdata <= rd_mux;
        else                rdata <= '0;
    end

    assign mode_e1 = mode_q;
    assign rx_off  = rx_off_q;
    assign tx_off  = tx_off_q;

    // R7
    mode_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(hw_hit || (wr_en && ready && acc.sel == RS_MODE)));

    // R5
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !hw_hit) |=> ($stable(rx_off_q) && $stable(tx_off_q) && $stable(mode_q)));

    // R5
    blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (rdata == '0));

endmodule

// File: rtl/rsg_link_gate.sv
module rsg_link_gate #(
    parameter int unsigned NUM_LINKS = 4
) (
    input  logic [NUM_LINKS-1:0] rx_off,
    input  logic [NUM_LINKS-1:0] tx_off,
    input  logic [NUM_LINKS-1:0] rx_in,
    input  logic [NUM_LINKS-1:0] tx_in,
    output logic [NUM_LINKS-1:0] rx_out,
    output logic [NUM_LINKS-1:0] tx_out,
    output logic [NUM_LINKS-1:0] tx_oe
);
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        assign rx_out[i] = rx_in[i] & ~rx_off[i];
        assign tx_out[i] = tx_in[i];
        assign tx_oe[i]  = ~tx_off[i];
    end
endmodule

// File: rtl/rsg_top.sv
module rsg_top
    import rsg_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 100_000_000,
    parameter longint unsigned PWRUP_MIN_US = 10_000,
    parameter longint unsigned RUN_MIN_NS   = 100,
    parameter longint unsigned SETTLE_US    = 2_000,
    parameter int unsigned     NUM_LINKS    = 4,
    parameter int unsigned     ADDR_W       = 4,
    parameter int unsigned     DATA_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_pin_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_ready,
    output logic                 in_powerup,
    output logic                 line_mode_e1,
    input  logic [NUM_LINKS-1:0] rx_line_i,
    output logic [NUM_LINKS-1:0] rx_line_o,
    input  logic [NUM_LINKS-1:0] tx_line_i,
    output logic [NUM_LINKS-1:0] tx_line_o,
    output logic [NUM_LINKS-1:0] tx_line_oe
);
    localparam int unsigned PWR_CYC    = 32'(ns_to_cyc(PWRUP_MIN_US * 64'd1000, CLK_HZ));
    localparam int unsigned RUN_CYC    = 32'(ns_to_cyc(RUN_MIN_NS, CLK_HZ));
    localparam int unsigned SETTLE_CYC = 32'(ns_to_cyc(SETTLE_US * 64'd1000, CLK_HZ));

    pin_ev_t              ev;
    logic                 sw_rst_req;
    logic [NUM_LINKS-1:0] rx_off, tx_off;

    rsg_pin_qual #(
        .RUN_CYC     (RUN_CYC),
        .PWR_CYC     (PWR_CYC),
        .SYNC_STAGES (2)
    ) u_qual (
        .clk   (clk),
        .rst   (rst),
        .pin_n (rst_pin_n),
        .pwrup (in_powerup),
        .ev    (ev)
    );

    rsg_sequencer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .sw_rst_req (sw_rst_req),
        .ready      (host_ready),
        .pwrup      (in_powerup)
    );

    rsg_regbank #(
        .NUM_LINKS (NUM_LINKS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .hw_hit     (ev.hit),
        .ready      (host_ready),
        .wr_en      (host_wr),
        .rd_en      (host_rd),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .rdata      (host_rdata),
        .sw_rst_req (sw_rst_req),
        .mode_e1    (line_mode_e1),
        .rx_off     (rx_off),
        .tx_off     (tx_off)
    );

    rsg_link_gate #(
        .NUM_LINKS (NUM_LINKS)
    ) u_gate (
        .rx_off (rx_off),
        .tx_off (tx_off),
        .rx_in  (rx_line_i),
        .tx_in  (tx_line_i),
        .rx_out (rx_line_o),
        .tx_out (tx_line_o),
        .tx_oe  (tx_line_oe)
    );

endmodule

// File: tb/sim_rsg_top.sv
module sim_rsg_top;
    // 100 MHz: power-up threshold 100 us, run threshold 20 ns, settle 20 us
    localparam int PWR = 10000;
    localparam int RUN = 2;
    localparam int SET = 2000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready, in_powerup, line_mode_e1;
    logic [3:0] rx_line_i = 4'hF, tx_line_i = 4'h0;
    logic [3:0] rx_line_o, tx_line_o, tx_line_oe;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct { string tag; logic [7:0] val; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    rsg_top #(
        .CLK_HZ(100_000_000), .PWRUP_MIN_US(100), .RUN_MIN_NS(20), .SETTLE_US(20),
        .NUM_LINKS(4), .ADDR_W(4), .DATA_W(8)
    ) u0 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .in_powerup(in_powerup), .line_mode_e1(line_mode_e1),
        .rx_line_i(rx_line_i), .rx_line_o(rx_line_o),
        .tx_line_i(tx_line_i), .tx_line_o(tx_line_o), .tx_line_oe(tx_line_oe)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: pushes the expected value, then issues the read
    task automatic host_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back('{tag: tag, val: exp});
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse(input int len);
        rst_pin_n = 1'b0;
        tick(len);
        rst_pin_n = 1'b1;
    endtask

    // Monitor: compares registered read data one cycle after each strobe
    initial begin
        forever begin
            @(posedge clk);
            if (host_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) check("R12 unexpected read", 32'(host_rdata), 32'hFFFF_FFFF);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, 32'(host_rdata), 32'(e.val));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 ready", 32'(host_ready), 0);
        check("R1 powerup", 32'(in_powerup), 1);
        check("R1 rx pass", 32'(rx_line_o), 32'hF);
        check("R1 tx oe", 32'(tx_line_oe), 32'hF);
        check("R1 mode", 32'(line_mode_e1), 0);
        // R5 read and write while blocked
        host_write(4'h1, 8'hFF);
        host_read(4'h1, 8'h00, "R5 read blocked");
        check("R5 write dropped", 32'(rx_line_o), 32'hF);

        // R2 short power-up pulse ignored
        pulse(PWR - 1);
        tick(50);
        check("R2 short ignored ready", 32'(host_ready), 0);
        check("R2 short ignored phase", 32'(in_powerup), 1);

        // R2 full-width pulse, R4 settle timing
        pulse(PWR);
        tick(1);
        check("R4 ready low in hold", 32'(host_ready), 0);
        tick(1 + SET);
        check("R4 ready still low", 32'(host_ready), 0);
        tick(1);
        check("R4 ready rises", 32'(host_ready), 1);
        check("R2 phase cleared", 32'(in_powerup), 0);

        // R8 pending, R7 mode, R9/R10 gating, R12 read path
        host_write(4'h0, 8'h01);
        host_read(4'h0, 8'h81, "R8 pending set");
        check("R7 mode out", 32'(line_mode_e1), 1);
        host_write(4'h1, 8'h21);
        check("R9 rx gated", 32'(rx_line_o), 32'hE);
        check("R10 tx oe", 32'(tx_line_oe), 32'hD);
        tx_line_i = 4'hA;
        tick(1);
        check("R10 tx data", 32'(tx_line_o), 32'hA);
        host_read(4'h1, 8'h21, "R12 pwrdn read");
        host_read(4'h2, 8'h00, "R12 swrst reads zero");
        host_read(4'h7, 8'h00, "R12 unmapped");
        tick(1);
        check("R12 idle rdata", 32'(host_rdata), 0);

        // R6 software reset; R5 accesses during its settle
        host_write(4'h2, 8'h00);
        check("R6 ready drops", 32'(host_ready), 0);
        host_write(4'h1, 8'h0F);
        host_read(4'h1, 8'h00, "R5 read during settle");
        tick(SET - 3);
        check("R6 ready low at end", 32'(host_ready), 0);
        tick(1);
        check("R6 ready back", 32'(host_ready), 1);
        host_read(4'h0, 8'h01, "R7 mode kept, R8 pending cleared");
        host_read(4'h1, 8'h00, "R6 pwrdn cleared");
        check("R6 rx restored", 32'(rx_line_o), 32'hF);

        // R3 short run pulse ignored
        host_write(4'h1, 8'h03);
        pulse(RUN - 1);
        tick(5);
        check("R3 short ignored ready", 32'(host_ready), 1);
        host_read(4'h0, 8'h01, "R3 mode untouched");
        host_read(4'h1, 8'h03, "R3 pwrdn untouched");

        // R3 qualifying run pulse clears everything incl. mode (R7)
        pulse(RUN);
        tick(2 + SET);
        check("R3 ready low", 32'(host_ready), 0);
        tick(1);
        check("R3 ready back", 32'(host_ready), 1);
        check("R2 phase stays clear", 32'(in_powerup), 0);
        host_read(4'h0, 8'h00, "R7 mode cleared by hw");
        host_read(4'h1, 8'h00, "R3 pwrdn cleared");

        // R11 software reset write on the hardware-acceptance edge
        host_write(4'h0, 8'h01);
        rst_pin_n = 1'b0;
        tick(RUN + 1);
        host_write(4'h2, 8'h00);
        rst_pin_n = 1'b1;
        tick(2 + SET);
        check("R11 ready low", 32'(host_ready), 0);
        tick(1);
        check("R11 ready timing", 32'(host_ready), 1);
        host_read(4'h0, 8'h00, "R11 hw wins mode cleared");

        // R9/R10 other pattern
        rx_line_i = 4'h5;
        host_write(4'h1, 8'hF0);
        check("R9 rx pass pattern", 32'(rx_line_o), 32'h5);
        check("R10 all oe off", 32'(tx_line_oe), 32'h0);
        host_write(4'h1, 8'h0C);
        check("R9 rx partial", 32'(rx_line_o), 32'h1);
        check("R10 oe on", 32'(tx_line_oe), 32'hF);

        tick(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule